// File: doc/BRIEF.md
# Banked Program Counter Sequencer

This block produces the instruction fetch address for a small 4-bit controller whose program space is divided into a bank, a page and a step. Each clock, a decoded operation code selects what happens to the address. The address can advance, load a pending bank/page pair, jump directly, jump conditionally or jump indirectly. It can also call a subroutine, return, return-and-skip, or take an interrupt vector. A pending bank/page pair, written by a page-set operation, supplies the upper address part of the next branch.

Calls and interrupts save a three-nibble return frame in a nibble-wide stack that lives in data memory. Returns read the frame back. Each stack transfer takes one clock per nibble, and the block raises a busy flag while it runs. Operation codes presented while busy are ignored. Stack read data is expected in the same cycle as the stack address.

Top module: `pcseq_top`

## Requirements
- R1: After reset the fetch address is bank 0, page RESET_PAGE (default 1), step 0. The stack pointer is SP_RST (default 0), and busy and the stack write strobe are low.
- R2: Operation code 1 (advance) adds one to the step, wrapping from 255 to 0 without touching page or bank. Code 0 (idle) and any code above 12 hold the address.
- R3: Code 2 (page set) stores immediate bit 4 as the pending bank and bits 3..0 as the pending page, and advances the step. Code 3 (jump) loads the pending bank, the pending page and the 8-bit immediate as the new bank, page and step.
- R4: Codes 4, 5, 6 and 7 jump like code 3 only when, respectively, carry is set, carry is clear, zero is set or zero is clear. Otherwise they advance the step.
- R5: Code 8 (indirect jump) loads the pending bank and page, with register B as step bits 7..4 and register A as step bits 3..0.
- R6: Code 9 (call) loads the pending page and the immediate step and keeps the bank. Over the next three cycles it writes step+1 bits 3..0, then the old page, then step+1 bits 7..4, to stack addresses SP-1, SP-2 and SP-3. The stack pointer drops by one each cycle.
- R7: Code 10 (return) reads the stack at SP, SP+1 and SP+2 over three cycles, as step high nibble, page and step low nibble. It raises SP by one each cycle and installs the new page and step at the end. Code 11 does the same and adds one to the step.
- R8: Code 12 (interrupt) jumps to page INT_PAGE (default 1), step equal to immediate bits 3..0, in the current bank. It pushes the current, un-incremented step and the page in the same order as R6.
- R9: After any executed jump, call, interrupt or return, the pending bank and page equal the new bank and page, so a page set steers only one branch.
- R10: While busy is high, the operation code has no effect on the address, the pending registers or the stack.
- R11: The stack pointer wraps modulo 256 in both directions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| op_i | input | 4 | Decoded operation code |
| imm_i | input | 8 | Immediate operand (step target, page-set value or vector) |
| reg_a_i | input | 4 | Register A, low step nibble for indirect jump |
| reg_b_i | input | 4 | Register B, high step nibble for indirect jump |
| flag_c_i | input | 1 | Carry flag |
| flag_z_i | input | 1 | Zero flag |
| stk_rdata_i | input | 4 | Stack read data for stk_addr_o, same cycle |
| pc_o | output | 13 | Fetch address {bank, page, step} |
| busy_o | output | 1 | Stack transfer in progress |
| sp_o | output | 8 | Stack pointer |
| stk_addr_o | output | 8 | Stack access address |
| stk_wdata_o | output | 4 | Stack write data |
| stk_we_o | output | 1 | Stack write strobe |

## Verification
The properties assume a defined operation code and defined flags in every cycle after reset, so each accepted code leads to exactly one next address. They also assume that the stack memory answers a read in the cycle its address is presented. The stimulus drives only the listed codes and changes inputs away from the clock edge. It backs the stack with a combinational-read memory, so a return always sees the nibbles a previous push wrote. Codes are sometimes issued during busy to confirm they are dropped.

// File: rtl/pcseq_pkg.sv
package pcseq_pkg;
  localparam int NIB_W  = 4;
  localparam int PAGE_W = NIB_W;
  localparam int STEP_W = 2 * NIB_W;
  localparam int OP_W   = 4;

  typedef enum logic [OP_W-1:0] {
    OP_IDLE = 4'd0,
    OP_NEXT = 4'd1,
    OP_PSET = 4'd2,
    OP_JP   = 4'd3,
    OP_JPC  = 4'd4,
    OP_JPNC = 4'd5,
    OP_JPZ  = 4'd6,
    OP_JPNZ = 4'd7,
    OP_JPBA = 4'd8,
    OP_CALL = 4'd9,
    OP_RET  = 4'd10,
    OP_RETS = 4'd11,
    OP_INT  = 4'd12
  } op_e;

  typedef enum logic [1:0] {STK_IDLE, STK_PUSH, STK_POP} stk_state_e;

  typedef struct packed {
    logic [NIB_W-1:0] hi;
    logic [NIB_W-1:0] pg;
    logic [NIB_W-1:0] lo;
  } ret_frame_t;
endpackage

// File: rtl/pcseq_target.sv
module pcseq_target
  import pcseq_pkg::*;
#(
  parameter int               BANK_W   = 1,
  parameter logic [PAGE_W-1:0] INT_PAGE = 1
) (
  input  op_e               op_i,
  input  logic [STEP_W-1:0] imm_i,
  input  logic [NIB_W-1:0]  reg_a_i,
  input  logic [NIB_W-1:0]  reg_b_i,
  input  logic              flag_c_i,
  input  logic              flag_z_i,
  input  logic [BANK_W-1:0] bank_i,
  input  logic [PAGE_W-1:0] page_i,
  input  logic [STEP_W-1:0] step_i,
  input  logic [BANK_W-1:0] nbank_i,
  input  logic [PAGE_W-1:0] npage_i,
  output logic              pc_ld_o,
  output logic [BANK_W-1:0] bank_nx_o,
  output logic [PAGE_W-1:0] page_nx_o,
  output logic [STEP_W-1:0] step_nx_o,
  output logic              reload_o,
  output logic              pset_o,
  output logic              push_o,
  output ret_frame_t        frame_o,
  output logic              pop_o,
  output logic              skip_o
);
  logic [STEP_W-1:0] step_inc;
  logic              jump_ok;

  assign step_inc = step_i + STEP_W'(1);

  always_comb begin
    case (op_i)
      OP_JP, OP_JPBA: jump_ok = 1'b1;
      OP_JPC:         jump_ok = flag_c_i;
      OP_JPNC:        jump_ok = !flag_c_i;
      OP_JPZ:         jump_ok = flag_z_i;
      OP_JPNZ:        jump_ok = !flag_z_i;
      default:        jump_ok = 1'b0;
    endcase
  end

  always_comb begin
    pc_ld_o   = 1'b0;
    bank_nx_o = bank_i;
    page_nx_o = page_i;
    step_nx_o = step_inc;
    reload_o  = 1'b0;
    pset_o    = 1'b0;
    push_o    = 1'b0;
    pop_o     = 1'b0;
    skip_o    = 1'b0;
    frame_o.hi = step_inc[STEP_W-1 -: NIB_W];
    frame_o.pg = page_i;
    frame_o.lo = step_inc[NIB_W-1:0];
    case (op_i)
      OP_NEXT: pc_ld_o = 1'b1;
      OP_PSET: begin
        pc_ld_o = 1'b1;
        pset_o  = 1'b1;
      end
      OP_JP, OP_JPC, OP_JPNC, OP_JPZ, OP_JPNZ, OP_JPBA: begin
        pc_ld_o = 1'b1;
        if (jump_ok) begin
          bank_nx_o = nbank_i;
          page_nx_o = npage_i;
          step_nx_o = (op_i == OP_JPBA) ? {reg_b_i, reg_a_i} : imm_i;
          reload_o  = 1'b1;
        end
      end
      OP_CALL: begin
        pc_ld_o   = 1'b1;
        page_nx_o = npage_i;     // bank deliberately kept
        step_nx_o = imm_i;
        reload_o  = 1'b1;
        push_o    = 1'b1;
      end
      OP_RET:  pop_o = 1'b1;
      OP_RETS: begin
        pop_o  = 1'b1;
        skip_o = 1'b1;
      end
      OP_INT: begin
        pc_ld_o    = 1'b1;
        page_nx_o  = INT_PAGE;
        step_nx_o  = {{(STEP_W-NIB_W){1'b0}}, imm_i[NIB_W-1:0]};
        reload_o   = 1'b1;
        push_o     = 1'b1;
        frame_o.hi = step_i[STEP_W-1 -: NIB_W];  // resume at interrupted step
        frame_o.lo = step_i[NIB_W-1:0];
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/pcseq_stack.sv
module pcseq_stack
  import pcseq_pkg::*;
#(
  parameter int              SP_W   = 8,
  parameter logic [SP_W-1:0] SP_RST = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  ret_frame_t       frame_i,
  input  logic             pop_i,
  input  logic [NIB_W-1:0] rdata_i,
  output logic             busy_o,
  output logic [SP_W-1:0]  sp_o,
  output logic [SP_W-1:0]  addr_o,
  output logic [NIB_W-1:0] wdata_o,
  output logic             we_o,
  output logic             pop_last_o,
  output logic [NIB_W-1:0] pop_hi_o,
  output logic [NIB_W-1:0] pop_pg_o
);
  localparam logic [1:0] LAST_IDX = 2'd2;

  stk_state_e       state_q;
  logic [1:0]       idx_q;
  logic [SP_W-1:0]  sp_q;
  ret_frame_t       frame_q;
  logic [NIB_W-1:0] hi_q, pg_q;

  assign busy_o     = (state_q != STK_IDLE);
  assign we_o       = (state_q == STK_PUSH);
  assign sp_o       = sp_q;
  assign addr_o     = we_o ? sp_q - SP_W'(1) : sp_q;
  assign pop_last_o = (state_q == STK_POP) && (idx_q == LAST_IDX);
  assign pop_hi_o   = hi_q;
  assign pop_pg_o   = pg_q;

  always_comb begin
    case (idx_q)
      2'd0:    wdata_o = frame_q.lo;
      2'd1:    wdata_o = frame_q.pg;
      default: wdata_o = frame_q.hi;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= STK_IDLE;
      idx_q   <= '0;
      sp_q    <= SP_RST;
      frame_q <= '0;
      hi_q    <= '0;
      pg_q    <= '0;
    end else begin
      case (state_q)
        STK_IDLE: begin
          idx_q <= '0;
          if (push_i) begin
            state_q <= STK_PUSH;
            frame_q <= frame_i;
          end else if (pop_i) begin
            state_q <= STK_POP;
          end
        end
        STK_PUSH: begin
          sp_q  <= sp_q - SP_W'(1);
          idx_q <= idx_q + 2'd1;
          if (idx_q == LAST_IDX) state_q <= STK_IDLE;
        end
        STK_POP: begin
          sp_q  <= sp_q + SP_W'(1);
          idx_q <= idx_q + 2'd1;
          if (idx_q == 2'd0) hi_q <= rdata_i;
          if (idx_q == 2'd1) pg_q <= rdata_i;
          if (idx_q == LAST_IDX) state_q <= STK_IDLE;
        end
        default: state_q <= STK_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pcseq_top.sv
module pcseq_top
  import pcseq_pkg::*;
#(
  parameter int                BANK_W     = 1,
  parameter int                SP_W       = 8,
  parameter logic [PAGE_W-1:0] RESET_PAGE = 1,
  parameter logic [PAGE_W-1:0] INT_PAGE   = 1,
  parameter logic [SP_W-1:0]   SP_RST     = '0,
  localparam int               PC_W       = BANK_W + PAGE_W + STEP_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [OP_W-1:0]   op_i,
  input  logic [STEP_W-1:0] imm_i,
  input  logic [NIB_W-1:0]  reg_a_i,
  input  logic [NIB_W-1:0]  reg_b_i,
  input  logic              flag_c_i,
  input  logic              flag_z_i,
  input  logic [NIB_W-1:0]  stk_rdata_i,
  output logic [PC_W-1:0]   pc_o,
  output logic              busy_o,
  output logic [SP_W-1:0]   sp_o,
  output logic [SP_W-1:0]   stk_addr_o,
  output logic [NIB_W-1:0]  stk_wdata_o,
  output logic              stk_we_o
);
  logic [BANK_W-1:0] bank_q, nbank_q, bank_nx;
  logic [PAGE_W-1:0] page_q, npage_q, page_nx;
  logic [STEP_W-1:0] step_q, step_nx;
  logic              skip_q;

  op_e        op_eff;
  logic       pc_ld, reload, pset, push_req, pop_req, pop_skip;
  ret_frame_t frame;
  logic       stk_busy, pop_last;
  logic [NIB_W-1:0] pop_hi, pop_pg;

  assign op_eff = stk_busy ? OP_IDLE : op_e'(op_i);

  pcseq_target #(.BANK_W(BANK_W), .INT_PAGE(INT_PAGE)) u_target (
    .op_i      (op_eff),
    .imm_i     (imm_i),
    .reg_a_i   (reg_a_i),
    .reg_b_i   (reg_b_i),
    .flag_c_i  (flag_c_i),
    .flag_z_i  (flag_z_i),
    .bank_i    (bank_q),
    .page_i    (page_q),
    .step_i    (step_q),
    .nbank_i   (nbank_q),
    .npage_i   (npage_q),
    .pc_ld_o   (pc_ld),
    .bank_nx_o (bank_nx),
    .page_nx_o (page_nx),
    .step_nx_o (step_nx),
    .reload_o  (reload),
    .pset_o    (pset),
    .push_o    (push_req),
    .frame_o   (frame),
    .pop_o     (pop_req),
    .skip_o    (pop_skip)
  );

  pcseq_stack #(.SP_W(SP_W), .SP_RST(SP_RST)) u_stack (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .push_i     (push_req),
    .frame_i    (frame),
    .pop_i      (pop_req),
    .rdata_i    (stk_rdata_i),
    .busy_o     (stk_busy),
    .sp_o       (sp_o),
    .addr_o     (stk_addr_o),
    .wdata_o    (stk_wdata_o),
    .we_o       (stk_we_o),
    .pop_last_o (pop_last),
    .pop_hi_o   (pop_hi),
    .pop_pg_o   (pop_pg)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bank_q  <= '0;
      page_q  <= RESET_PAGE;
      step_q  <= '0;
      nbank_q <= '0;
      npage_q <= RESET_PAGE;
      skip_q  <= 1'b0;
    end else if (pop_last) begin
      // last nibble arrives combinationally this cycle
      step_q  <= {pop_hi, stk_rdata_i} + STEP_W'(skip_q);
      page_q  <= pop_pg;
      nbank_q <= bank_q;
      npage_q <= pop_pg;
    end else begin
      if (pop_req) skip_q <= pop_skip;
      if (pc_ld) begin
        bank_q <= bank_nx;
        page_q <= page_nx;
        step_q <= step_nx;
      end
      if (reload) begin
        nbank_q <= bank_nx;
        npage_q <= page_nx;
      end else if (pset) begin
        nbank_q <= imm_i[PAGE_W +: BANK_W];
        npage_q <= imm_i[PAGE_W-1:0];
      end
    end
  end

  assign pc_o   = {bank_q, page_q, step_q};
  assign busy_o = stk_busy;
endmodule

// File: rtl/pcseq_chk.sv
module pcseq_chk
  import pcseq_pkg::*;
#(
  parameter int                BANK_W   = 1,
  parameter int                SP_W     = 8,
  parameter logic [PAGE_W-1:0] INT_PAGE = 1,
  localparam int               PC_W     = BANK_W + PAGE_W + STEP_W
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [OP_W-1:0]   op_i,
  input logic              flag_c_i,
  input logic [PC_W-1:0]   pc_o,
  input logic              busy_o,
  input logic [SP_W-1:0]   sp_o,
  input logic              stk_we_o
);
  // R2
  next_inc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && op_i == 4'd1) |=>
      (pc_o[STEP_W-1:0] == STEP_W'($past(pc_o[STEP_W-1:0]) + STEP_W'(1))) &&
      (pc_o[PC_W-1:STEP_W] == $past(pc_o[PC_W-1:STEP_W])));

  // R4
  jpc_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && op_i == 4'd4 && !flag_c_i) |=>
      pc_o[STEP_W-1:0] == STEP_W'($past(pc_o[STEP_W-1:0]) + STEP_W'(1)));

  // R6
  call_bank_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && op_i == 4'd9) |=> pc_o[PC_W-1 -: BANK_W] == $past(pc_o[PC_W-1 -: BANK_W]));

  // R6
  push_sp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stk_we_o |=> sp_o == SP_W'($past(sp_o) - SP_W'(1)));

  // R8
  int_vec_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && op_i == 4'd12) |=>
      (pc_o[STEP_W +: PAGE_W] == INT_PAGE) && (pc_o[STEP_W-1:NIB_W] == '0));

  // R10
  busy_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && stk_we_o) |=> $stable(pc_o));

  // R11
  idle_sp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |=> $stable(sp_o));
endmodule

bind pcseq_top pcseq_chk #(.BANK_W(BANK_W), .SP_W(SP_W), .INT_PAGE(INT_PAGE)) pcseq_chk_i (.*);

// File: tb/pcseq_top_tb_top.sv
module pcseq_top_tb_top;
  localparam int C_IDLE = 0, C_NEXT = 1, C_PSET = 2, C_JP = 3, C_JPC = 4, C_JPNC = 5;
  localparam int C_JPZ = 6, C_JPNZ = 7, C_JPBA = 8, C_CALL = 9, C_RET = 10, C_RETS = 11, C_INT = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic [3:0]  op = '0;
  logic [7:0]  imm = '0;
  logic [3:0]  ra = '0, rb = '0;
  logic        fc = 1'b0, fz = 1'b0;
  logic [3:0]  rdata;
  logic [12:0] pc;
  logic        busy, we;
  logic [7:0]  sp, saddr;
  logic [3:0]  wdata;
  logic [3:0]  mem [256];

  assign rdata = mem[saddr];
  always @(posedge clk) if (we) mem[saddr] <= wdata;

  pcseq_top dut_i (
    .clk_i(clk), .rst_ni(rst_n), .op_i(op), .imm_i(imm), .reg_a_i(ra), .reg_b_i(rb),
    .flag_c_i(fc), .flag_z_i(fz), .stk_rdata_i(rdata), .pc_o(pc), .busy_o(busy),
    .sp_o(sp), .stk_addr_o(saddr), .stk_wdata_o(wdata), .stk_we_o(we)
  );

  int n_chk = 0, n_fail = 0;
  string cur_req = "R1";
  bit done = 1'b0;

  // behavioural reference
  int m_bank, m_page, m_step, m_nb, m_np, m_sp, pop_left, r;
  bit m_skip, tk;
  int push_q[$];
  int pop_vals[$];
  int m_mem[256];

  function automatic void m_jump(int st);
    m_bank = m_nb; m_page = m_np; m_step = st;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_bank = 0; m_page = 1; m_step = 0; m_nb = 0; m_np = 1; m_sp = 0;
      pop_left = 0; m_skip = 0; push_q.delete(); pop_vals.delete();
    end else if (push_q.size() > 0) begin
      m_sp = (m_sp + 255) % 256;
      m_mem[m_sp] = push_q.pop_front();
    end else if (pop_left > 0) begin
      pop_vals.push_back(m_mem[m_sp]);
      m_sp = (m_sp + 1) % 256;
      pop_left--;
      if (pop_left == 0) begin
        m_step = (pop_vals[0] * 16 + pop_vals[2] + int'(m_skip)) % 256;
        m_page = pop_vals[1];
        m_nb = m_bank; m_np = m_page;
      end
    end else begin
      case (int'(op))
        C_NEXT: m_step = (m_step + 1) % 256;
        C_PSET: begin m_nb = imm[4]; m_np = imm[3:0]; m_step = (m_step + 1) % 256; end
        C_JP, C_JPC, C_JPNC, C_JPZ, C_JPNZ, C_JPBA: begin
          tk = (op == C_JP) || (op == C_JPBA) || (op == C_JPC && fc) || (op == C_JPNC && !fc) ||
               (op == C_JPZ && fz) || (op == C_JPNZ && !fz);
          if (tk) begin
            m_jump(op == C_JPBA ? int'(rb) * 16 + int'(ra) : int'(imm));
            m_nb = m_bank; m_np = m_page;
          end else m_step = (m_step + 1) % 256;
        end
        C_CALL: begin
          r = (m_step + 1) % 256;
          push_q = '{r % 16, m_page, r / 16};
          m_page = m_np; m_step = imm; m_nb = m_bank;
        end
        C_INT: begin
          push_q = '{m_step % 16, m_page, m_step / 16};
          m_page = 1; m_step = imm % 16; m_nb = m_bank; m_np = m_page;
        end
        C_RET, C_RETS: begin pop_left = 3; m_skip = (op == C_RETS); pop_vals.delete(); end
        default: ;
      endcase
      if (op == C_CALL) m_np = m_page;
    end
  end

  task automatic chk(string what, int act, int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", cur_req, what, act, exp);
    end
  endtask

  task automatic compare();
    chk("pc", int'(pc), m_bank * 4096 + m_page * 256 + m_step);
    chk("sp", int'(sp), m_sp);
    chk("busy", int'(busy), int'(push_q.size() > 0 || pop_left > 0));
    chk("we", int'(we), int'(push_q.size() > 0));
    if (push_q.size() > 0) begin
      chk("addr", int'(saddr), (m_sp + 255) % 256);
      chk("wdata", int'(wdata), push_q[0]);
    end else if (pop_left > 0) begin
      chk("addr", int'(saddr), m_sp);
    end
  endtask

  task automatic cyc(int o, int i = 0);
    op = 4'(o); imm = 8'(i);
    @(negedge clk);
    compare();
  endtask

  task automatic drain();
    while (push_q.size() > 0 || pop_left > 0) cyc(C_IDLE);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    cur_req = "R1"; compare();
    cur_req = "R2"; cyc(C_IDLE); cyc(15); cyc(C_NEXT); cyc(C_NEXT); cyc(C_NEXT);
    cur_req = "R3"; cyc(C_PSET, 'h13); cyc(C_NEXT); cyc(C_JP, 'h40);
    cur_req = "R9"; cyc(C_JP, 'h50);
    cur_req = "R4";
    fc = 0; cyc(C_JPC, 'h60); fc = 1; cyc(C_JPC, 'h60); cyc(C_JPNC, 'h70);
    fz = 1; cyc(C_JPZ, 'h80); cyc(C_JPNZ, 'h90); fz = 0; cyc(C_JPNZ, 'h90);
    cur_req = "R5"; cyc(C_PSET, 'h05); ra = 4'h5; rb = 4'hA; cyc(C_JPBA);
    cur_req = "R6"; cyc(C_PSET, 'h17); cyc(C_CALL, 'h20);
    cur_req = "R10"; cyc(C_JP, 'hFF); cyc(C_NEXT); cyc(C_INT, 3); drain();
    cur_req = "R7"; cyc(C_NEXT); cyc(C_RET); drain();
    cur_req = "R11"; cyc(C_CALL, 'h30); drain(); cyc(C_RETS); drain();
    cur_req = "R8"; cyc(C_INT, 'h03); drain(); cyc(C_NEXT); cyc(C_RET); drain();
    cur_req = "R2"; cyc(C_JP, 'hFF); cyc(C_NEXT);
    cur_req = "R11"; cyc(C_CALL, 'h10); drain(); cyc(C_CALL, 'h11); drain();
    cyc(C_RET); cyc(C_PSET, 'h1F); drain(); cyc(C_RET); drain();
    cur_req = "R9"; cyc(C_PSET, 'h12); cyc(C_JP, 'h05); cyc(C_JP, 'h06);
    repeat (2) cyc(C_IDLE);
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      summary();
      $finish;
    end
  end
endmodule